// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block chooses, every cycle, which pending request a processor core should take next. It holds one 8-bit software priority for each configurable interrupt line and a 3-bit grouping selector. A smaller priority value means a more urgent request. Among configurable lines the smallest value wins, and on a tie the lower line number wins. Three fixed system exceptions (reset, non-maskable interrupt, hard fault) carry the signed priorities -3, -2 and -1. They outrank every configurable line whatever its setting.

The grouping selector g divides each priority into a group part (bits above g) and a subpriority part (bits g down to 0). The full value still orders requests, so the group decides first and the subpriority then settles the order inside a group. Only the group part is compared against the group priority of the exception now being serviced. The block raises a pre-empt request when the winner's group is strictly more urgent than that active group, or when nothing is active.

Selection is purely combinational from the pending inputs. Register writes take effect from the cycle after the write edge. The surrounding core uses the winner's exception number, priority and group, plus the pre-empt flag, to decide whether to begin exception entry.

Top module: `grp_prio_arbiter`

## Requirements
- R1: After reset every line priority reads as 0 and the grouping selector as 0, so with all lines pending, line 0 (exception number 16) wins with priority 0.
- R2: A write with `prio_we` high stores `prio_wdata` as the priority of line `prio_idx`. It takes effect from the cycle after the clock edge that samples it.
- R3: Among pending configurable lines, the numerically smallest priority wins, regardless of line number.
- R4: Among pending configurable lines with equal priority, the lowest line number wins.
- R5: Pending system exceptions win over all lines in the order reset (bit 0 of `sys_pend`, number 1, priority -3), non-maskable (bit 1, number 2, priority -2), hard fault (bit 2, number 3, priority -1).
- R6: `win_num` is 16 plus the line index for a configurable line. With nothing pending, `win_valid`, `win_num`, `win_prio`, `win_grp` and `preempt` are all 0.
- R7: A write with `grp_we` high loads `grp_wdata` into the grouping selector g, effective from the next cycle. `win_grp` equals the winner's priority with bits [g:0] cleared, or equals the signed priority itself for a system exception.
- R8: `preempt` is high exactly when a winner exists and either `act_valid` is low or `win_grp` is less than `act_grp` in a signed comparison.
- R9: A winner whose group equals the active group never pre-empts, however much smaller its subpriority is. With g=7 every configurable line has group 0.
- R10: All winner outputs follow `sys_pend`, `irq_pend`, `act_valid` and `act_grp` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_we | input | 1 | Priority register write strobe |
| prio_idx | input | clog2(NUM_IRQ) | Line whose priority is written |
| prio_wdata | input | 8 | Priority value to store |
| grp_we | input | 1 | Grouping selector write strobe |
| grp_wdata | input | 3 | New grouping selector value |
| sys_pend | input | 3 | Pending system exceptions: bit0 reset, bit1 non-maskable, bit2 hard fault |
| irq_pend | input | NUM_IRQ | Pending configurable lines |
| act_valid | input | 1 | An exception is currently active |
| act_grp | input | 9 (signed) | Group priority of the active exception |
| win_valid | output | 1 | Some request is pending |
| win_num | output | clog2(16+NUM_IRQ) | Exception number of the winner |
| win_prio | output | 9 (signed) | Full priority of the winner |
| win_grp | output | 9 (signed) | Group priority of the winner |
| preempt | output | 1 | Winner may pre-empt the active exception |

## Verification
The winner outputs and `preempt` are due in the same cycle as a change on the pending and active inputs. The bench therefore drives those inputs just after a falling edge and samples 1 ns later, with no clock edge in between. A priority or grouping write is due one rising edge after it is presented, so the bench raises the strobe after a falling edge, drops it at the next falling edge, and only then applies pending patterns. A small configuration of eight lines is swept through all 256 pending patterns, for each of the eight grouping values and several priority sets. The sweep uses tie-heavy and spread priority sets, and the expected winner and pre-empt decision come from an in-order scan in the bench.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  localparam int PRIO_W   = 8;
  localparam int GSEL_W   = 3;
  localparam int SPRIO_W  = PRIO_W + 1;
  localparam int NUM_SYS  = 3;
  localparam int IRQ_BASE = 16;

  typedef logic signed [SPRIO_W-1:0] sprio_t;

  // system exception k (0 reset, 1 non-maskable, 2 hard fault)
  function automatic sprio_t sys_prio(input int k);
    return sprio_t'(k - NUM_SYS);
  endfunction

  function automatic int sys_num(input int k);
    return k + 1;
  endfunction

  // bits strictly above g form the group field
  function automatic logic [PRIO_W-1:0] group_mask(input logic [GSEL_W-1:0] g);
    logic [PRIO_W-1:0] m;
    for (int b = 0; b < PRIO_W; b++) m[b] = (b > int'(g));
    return m;
  endfunction

  function automatic sprio_t widen(input logic [PRIO_W-1:0] p);
    return sprio_t'({1'b0, p});
  endfunction

  function automatic sprio_t group_of(input sprio_t p, input logic [GSEL_W-1:0] g);
    if (p < 0) return p;
    return widen(p[PRIO_W-1:0] & group_mask(g));
  endfunction

  // left operand holds the lower line numbers, so it keeps ties
  function automatic logic left_wins(input logic va, input logic [PRIO_W-1:0] pa,
                                     input logic vb, input logic [PRIO_W-1:0] pb);
    return va && (!vb || pa <= pb);
  endfunction
endpackage

// File: rtl/gpa_prio_regs.sv
module gpa_prio_regs
  import gpa_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prio_we,
  input  logic [IDX_W-1:0]    prio_idx,
  input  logic [PRIO_W-1:0]   prio_wdata,
  input  logic                grp_we,
  input  logic [GSEL_W-1:0]   grp_wdata,
  output logic [PRIO_W-1:0]   prio_q [NUM_IRQ],
  output logic [GSEL_W-1:0]   grp_q
);
  logic [NUM_IRQ-1:0] line_we;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign line_we[i] = prio_we && (prio_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio_q[i] <= '0;
      else if (line_we[i]) prio_q[i] <= prio_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grp_q <= '0;
    else if (grp_we) grp_q <= grp_wdata;
  end
endmodule

// File: rtl/gpa_cmp_tree.sv
module gpa_cmp_tree
  import gpa_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int LEAVES = 1 << IDX_W,
  localparam int NODES  = 2 * LEAVES - 1
) (
  input  logic [NUM_IRQ-1:0] req,
  input  logic [PRIO_W-1:0]  prio [NUM_IRQ],
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [PRIO_W-1:0]  best
);
  // heap layout: node n has children 2n+1 (lower lines) and 2n+2
  logic [NODES-1:0]  nd_v;
  logic [PRIO_W-1:0] nd_p [NODES];
  logic [IDX_W-1:0]  nd_i [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NUM_IRQ) begin : g_real
      assign nd_v[LEAVES-1+k] = req[k];
      assign nd_p[LEAVES-1+k] = prio[k];
    end else begin : g_pad
      assign nd_v[LEAVES-1+k] = 1'b0;
      assign nd_p[LEAVES-1+k] = '1;
    end
    assign nd_i[LEAVES-1+k] = IDX_W'(k);
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic take_l;
    assign take_l  = left_wins(nd_v[2*n+1], nd_p[2*n+1], nd_v[2*n+2], nd_p[2*n+2]);
    assign nd_v[n] = nd_v[2*n+1] | nd_v[2*n+2];
    assign nd_p[n] = take_l ? nd_p[2*n+1] : nd_p[2*n+2];
    assign nd_i[n] = take_l ? nd_i[2*n+1] : nd_i[2*n+2];
  end

  assign any  = nd_v[0];
  assign idx  = nd_v[0] ? nd_i[0] : '0;
  assign best = nd_v[0] ? nd_p[0] : '0;
endmodule

// File: rtl/gpa_sys_sel.sv
module gpa_sys_sel
  import gpa_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = $clog2(NUM_IRQ),
  localparam int EXC_W = $clog2(IRQ_BASE + NUM_IRQ)
) (
  input  logic [NUM_SYS-1:0] sys_pend,
  input  logic               line_any,
  input  logic [IDX_W-1:0]   line_idx,
  input  logic [PRIO_W-1:0]  line_prio,
  output logic               win_valid,
  output logic               win_is_sys,
  output logic [EXC_W-1:0]   win_num,
  output sprio_t             win_prio
);
  always_comb begin
    win_valid  = line_any;
    win_is_sys = 1'b0;
    win_num    = line_any ? EXC_W'(IRQ_BASE) + EXC_W'(line_idx) : '0;
    win_prio   = line_any ? widen(line_prio) : '0;
    // highest index first so that bit 0 has the final say
    for (int k = NUM_SYS - 1; k >= 0; k--) begin
      if (sys_pend[k]) begin
        win_valid  = 1'b1;
        win_is_sys = 1'b1;
        win_num    = EXC_W'(sys_num(k));
        win_prio   = sys_prio(k);
      end
    end
  end
endmodule

// File: rtl/gpa_preempt.sv
module gpa_preempt
  import gpa_pkg::*;
(
  input  logic              win_valid,
  input  sprio_t            win_prio,
  input  logic [GSEL_W-1:0] grp_sel,
  input  logic              act_valid,
  input  sprio_t            act_grp,
  output sprio_t            win_grp,
  output logic              preempt
);
  logic grp_more_urgent;

  assign win_grp         = win_valid ? group_of(win_prio, grp_sel) : '0;
  assign grp_more_urgent = win_grp < act_grp;
  assign preempt         = win_valid && (!act_valid || grp_more_urgent);
endmodule

// File: rtl/grp_prio_arbiter.sv
module grp_prio_arbiter
  import gpa_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = $clog2(NUM_IRQ),
  localparam int EXC_W = $clog2(IRQ_BASE + NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prio_we,
  input  logic [IDX_W-1:0]          prio_idx,
  input  logic [7:0]                prio_wdata,
  input  logic                      grp_we,
  input  logic [2:0]                grp_wdata,
  input  logic [2:0]                sys_pend,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic                      act_valid,
  input  logic signed [8:0]         act_grp,
  output logic                      win_valid,
  output logic [EXC_W-1:0]          win_num,
  output logic signed [8:0]         win_prio,
  output logic signed [8:0]         win_grp,
  output logic                      preempt
);
  // named internal events, observed by the bound checker
  logic [PRIO_W-1:0] prio_q [NUM_IRQ];
  logic [GSEL_W-1:0] grp_q;
  logic              line_any;
  logic [IDX_W-1:0]  line_idx;
  logic [PRIO_W-1:0] line_prio;
  logic              win_is_sys;

  gpa_prio_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .prio_we    (prio_we),
    .prio_idx   (prio_idx),
    .prio_wdata (prio_wdata),
    .grp_we     (grp_we),
    .grp_wdata  (grp_wdata),
    .prio_q     (prio_q),
    .grp_q      (grp_q)
  );

  gpa_cmp_tree #(.NUM_IRQ(NUM_IRQ)) u_tree (
    .req  (irq_pend),
    .prio (prio_q),
    .any  (line_any),
    .idx  (line_idx),
    .best (line_prio)
  );

  gpa_sys_sel #(.NUM_IRQ(NUM_IRQ)) u_sys (
    .sys_pend   (sys_pend),
    .line_any   (line_any),
    .line_idx   (line_idx),
    .line_prio  (line_prio),
    .win_valid  (win_valid),
    .win_is_sys (win_is_sys),
    .win_num    (win_num),
    .win_prio   (win_prio)
  );

  gpa_preempt u_pre (
    .win_valid (win_valid),
    .win_prio  (win_prio),
    .grp_sel   (grp_q),
    .act_valid (act_valid),
    .act_grp   (act_grp),
    .win_grp   (win_grp),
    .preempt   (preempt)
  );
endmodule

// File: rtl/gpa_checker.sv
module gpa_checker
  import gpa_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W = $clog2(NUM_IRQ),
  localparam int EXC_W = $clog2(IRQ_BASE + NUM_IRQ)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                prio_we,
  input logic [IDX_W-1:0]    prio_idx,
  input logic [7:0]          prio_wdata,
  input logic                grp_we,
  input logic [2:0]          grp_wdata,
  input logic [PRIO_W-1:0]   prio_q [NUM_IRQ],
  input logic [GSEL_W-1:0]   grp_q,
  input logic [2:0]          sys_pend,
  input logic [NUM_IRQ-1:0]  irq_pend,
  input logic                act_valid,
  input logic signed [8:0]   act_grp,
  input logic                win_valid,
  input logic                win_is_sys,
  input logic [EXC_W-1:0]    win_num,
  input logic signed [8:0]   win_prio,
  input logic signed [8:0]   win_grp,
  input logic                preempt
);
  logic [IDX_W-1:0] won_line;
  assign won_line = IDX_W'(win_num - EXC_W'(IRQ_BASE));

  assert_prio_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prio_we |=> prio_q[$past(prio_idx)] == $past(prio_wdata));

  assert_grp_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_we |=> grp_q == $past(grp_wdata));

  assert_reset_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_pend[0] |-> (win_num == EXC_W'(1) && win_prio == -9'sd3));

  assert_valid_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (|sys_pend || |irq_pend));

  assert_line_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_is_sys) |-> irq_pend[won_line]);

  assert_preempt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> (win_valid && (!act_valid || win_grp < act_grp)));

  assert_same_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && act_valid && win_grp == act_grp) |-> !preempt);

  assert_group_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_grp <= win_prio);
endmodule

bind grp_prio_arbiter gpa_checker #(.NUM_IRQ(NUM_IRQ)) u_gpa_checker (.*);

// File: tb/test_grp_prio_arbiter.sv
module test_grp_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 8;
  localparam int IW   = $clog2(NIRQ);
  localparam int EW   = $clog2(16 + NIRQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prio_we = 1'b0;
  logic [IW-1:0] prio_idx = '0;
  logic [7:0] prio_wdata = '0;
  logic grp_we = 1'b0;
  logic [2:0] grp_wdata = '0;
  logic [2:0] sys_pend = '0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic act_valid = 1'b0;
  logic signed [8:0] act_grp = '0;
  logic win_valid;
  logic [EW-1:0] win_num;
  logic signed [8:0] win_prio;
  logic signed [8:0] win_grp;
  logic preempt;

  int total = 0;
  int bad = 0;
  int mprio [NIRQ];
  int mgrp = 0;
  int unsigned seed = 32'h1234_5678;

  grp_prio_arbiter #(.NUM_IRQ(NIRQ)) i_grp_prio_arbiter (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]);
  endfunction

  task automatic wr_prio(input int idx, input int val);
    @(negedge clk);
    prio_we = 1'b1; prio_idx = IW'(idx); prio_wdata = 8'(val);
    @(negedge clk);
    prio_we = 1'b0;
    mprio[idx] = val;
  endtask

  task automatic wr_grp(input int g);
    @(negedge clk);
    grp_we = 1'b1; grp_wdata = 3'(g);
    @(negedge clk);
    grp_we = 1'b0;
    mgrp = g;
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference: in-order scan of the lines, then arithmetic group split
  task automatic check_now(input string tag);
    int ev = 0, en = 0, ep = 0, eg = 0, epre = 0;
    int step;
    if (sys_pend[0])      begin ev = 1; en = 1; ep = -3; end
    else if (sys_pend[1]) begin ev = 1; en = 2; ep = -2; end
    else if (sys_pend[2]) begin ev = 1; en = 3; ep = -1; end
    else begin
      for (int i = 0; i < NIRQ; i++) begin
        if (irq_pend[i] && (ev == 0 || mprio[i] < ep)) begin
          ev = 1; en = 16 + i; ep = mprio[i];
        end
      end
    end
    if (ev != 0) begin
      step = 2 ** (mgrp + 1);
      eg = (ep < 0) ? ep : (ep / step) * step;
      epre = (!act_valid || eg < int'(act_grp)) ? 1 : 0;
    end
    cmp(tag, "win_valid", int'(win_valid), ev);
    cmp(tag, "win_num", int'(win_num), en);
    cmp(tag, "win_prio", int'(win_prio), ep);
    cmp(tag, "win_grp", int'(win_grp), eg);
    cmp(tag, "preempt", int'(preempt), epre);
  endtask

  task automatic apply(input logic [2:0] s, input logic [NIRQ-1:0] p,
                       input logic av, input int ag, input string tag);
    @(negedge clk);
    sys_pend = s; irq_pend = p; act_valid = av; act_grp = 9'(ag);
    #1;
    check_now(tag);
  endtask

  initial begin
    for (int i = 0; i < NIRQ; i++) mprio[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared state, all lines tie at 0 and line 0 wins
    apply(3'b000, '1, 1'b0, 0, "R1");
    cmp("R1", "win_num direct", int'(win_num), 16);

    // R6: nothing pending gives all-zero outputs
    apply(3'b000, '0, 1'b1, 5, "R6");

    // R2 R3: line 7 at 0 beats line 0 at 1
    for (int i = 0; i < NIRQ; i++) wr_prio(i, 200);
    wr_prio(0, 1);
    wr_prio(7, 0);
    apply(3'b000, 8'h81, 1'b0, 0, "R2 R3");
    cmp("R3", "win_num direct", int'(win_num), 23);

    // R4: equal priorities, lower line wins
    apply(3'b000, 8'b0010_0100, 1'b0, 0, "R4");
    cmp("R4", "win_num direct", int'(win_num), 18);

    // R5: system exceptions in fixed order above every line
    apply(3'b111, '1, 1'b1, -3, "R5");
    apply(3'b110, '1, 1'b1, -3, "R5");
    apply(3'b100, '1, 1'b0, 0, "R5");
    cmp("R5", "win_prio hard fault", int'(win_prio), -1);

    // R7 R8 R9: grouping g=3 on priority 0x35
    wr_prio(0, 8'h35);
    wr_grp(3);
    apply(3'b000, 8'h01, 1'b1, 8'h30, "R9");
    cmp("R7", "win_grp split", int'(win_grp), 8'h30);
    apply(3'b000, 8'h01, 1'b1, 8'h40, "R8");
    cmp("R8", "preempt direct", int'(preempt), 1);
    wr_grp(7);
    apply(3'b000, 8'h01, 1'b1, 0, "R9");
    cmp("R9", "preempt g7", int'(preempt), 0);

    // R10: a same-cycle change of the pending input moves the winner
    @(negedge clk);
    irq_pend = 8'h80; sys_pend = '0; act_valid = 1'b0;
    #1;
    cmp("R10", "win_num first", int'(win_num), 23);
    irq_pend = 8'h40;
    #1;
    cmp("R10", "win_num same cycle", int'(win_num), 22);

    // sweep: priority sets x grouping x every pending pattern
    for (int set = 0; set < 6; set++) begin
      for (int i = 0; i < NIRQ; i++) wr_prio(i, (set < 2) ? rnd() % 4 : rnd());
      for (int g = 0; g < 8; g++) begin
        wr_grp(g);
        for (int p = 0; p < 256; p++) begin
          int r = rnd();
          logic [2:0] s;
          s = (r % 16 == 0) ? 3'(rnd()) : 3'b000;
          apply(s, 8'(p), 1'(rnd() % 4 != 0), (rnd() % 256) + (rnd() % 8) - 4,
                "R3 R4 R7 R8 sweep");
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule